// File: doc/BRIEF.md
# Filtered Event Counter with Overflow Request

This block is a single 64-bit hardware event counter paired with its event-selector register. Each cycle, a small code field in the selector picks one line of an event-pulse vector. That pulse advances the counter by one, unless the core's current privilege level is masked by one of five per-level inhibit bits. When the counter carries out of its top bit, it wraps and keeps counting.

The top bit of the selector is a sticky overflow flag. It also serves as the interrupt disable. A carry that finds the flag clear sets the flag and raises a one-cycle overflow request. A carry that finds the flag already set raises nothing.

A 32-bit host reaches both registers through one CSR port. The port has a register select, a half select and a write strobe. Reads are combinational. Writes take effect at the next clock edge.

Top module: `hpc_unit`

## Requirements
- R1: After reset the counter is 0, the selector is 0 and the overflow request is low.
- R2: The selector code field is bits 3:0. A code k in 1..15 selects `evt_i[k-1]`. The counter advances by exactly one on each clock edge where the selected pulse is high and counting is not inhibited. Pulses on unselected lines have no effect.
- R3: The privilege encoding is 0=M, 1=S/HS, 2=U, 3=VS, 4=VU. Selector bit 62 stops counting in M, bit 61 in S/HS, bit 60 in U, bit 59 in VS and bit 58 in VU. With all five bits clear, every level counts.
- R4: A selector code of 0, which includes an all-zero selector, counts nothing.
- R5: Overflow is an unsigned carry out of bit 63. The counter wraps to 0 and continues counting on later events.
- R6: An overflow while selector bit 63 is 0 sets bit 63 and drives `irq_o` high for exactly one cycle, in the same cycle in which the flag is seen set.
- R7: An overflow while selector bit 63 is 1 leaves it at 1 and raises no request. Only a software write changes bit 63.
- R8: `csr_reg_i`=0 addresses the counter and 1 addresses the selector. `csr_hi_i`=0 reaches bits 31:0 and 1 reaches bits 63:32. A write replaces only that half. `csr_rdata_o` returns the addressed half in the same cycle.
- R9: Selector bits 57:4 are not writable and always read as 0.
- R10: A counter write in the same cycle as a counted event wins. The written value is stored and the event is lost.
- R11: A write to the selector's upper half in the same cycle as an overflow keeps the written bit 63 and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 15 | Event pulses, one per line |
| priv_i | input | 3 | Current privilege level code |
| csr_we_i | input | 1 | CSR write strobe |
| csr_reg_i | input | 1 | Register select: 0 counter, 1 selector |
| csr_hi_i | input | 1 | Half select: 0 low word, 1 high word |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | Addressed half of the addressed register |
| cnt_o | output | 64 | Counter value |
| sel_o | output | 64 | Selector value |
| of_o | output | 1 | Sticky overflow flag (selector bit 63) |
| irq_o | output | 1 | One-cycle overflow request |

## Verification
Software writes can coincide with the hardware's own updates in two ways. A counter write can land on a cycle with a counted event. A write to the selector's upper half can land on the cycle where the counter carries out. The bench provokes the first case by holding the selected event high while it writes the counter's low word. It expects the written word exactly, not the written word plus one. It provokes the second case by presetting the counter to all ones with the flag clear, then writing zero to the selector's upper half together with the final event. It expects a wrapped counter, a flag that stays clear and no request pulse.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int CNT_W     = 64;
  localparam int HALF_W    = 32;
  localparam int NHALF     = CNT_W / HALF_W;
  localparam int OF_BIT    = CNT_W - 1;
  localparam int NUM_MODES = 5;
  localparam int INH_TOP   = OF_BIT - 1;

  typedef enum logic [2:0] {
    PRIV_M  = 3'd0,
    PRIV_S  = 3'd1,
    PRIV_U  = 3'd2,
    PRIV_VS = 3'd3,
    PRIV_VU = 3'd4
  } priv_e;

  // writable selector bits: flag, inhibits, event code
  function automatic logic [CNT_W-1:0] sel_wmask(input int evt_w);
    logic [CNT_W-1:0] m;
    m = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b >= INH_TOP - NUM_MODES + 1 || b < evt_w) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/hpc_mode_gate.sv
module hpc_mode_gate
  import hpc_pkg::*;
#(
  parameter int NUM_EVT = 15,
  parameter int EVT_W   = 4
) (
  input  logic [NUM_EVT-1:0]   evt_i,
  input  logic [EVT_W-1:0]     code_i,
  input  logic [NUM_MODES-1:0] inh_i,
  input  logic [2:0]           priv_i,
  output logic                 en_o
);
  logic [NUM_EVT-1:0]   pick;
  logic [NUM_MODES-1:0] blocked;

  // code k (k>=1) routes event line k-1; code 0 routes nothing
  for (genvar k = 0; k < NUM_EVT; k++) begin : g_pick
    assign pick[k] = evt_i[k] && (code_i == EVT_W'(k + 1));
  end

  // a set inhibit bit blocks only its own privilege level
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    assign blocked[m] = inh_i[m] && (priv_i == 3'(m));
  end

  assign en_o = (|pick) && !(|blocked);
endmodule

// File: rtl/hpc_count_reg.sv
module hpc_count_reg
  import hpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NHALF-1:0]  wr_half_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              inc_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             any_wr;

  assign any_wr = |wr_half_i;

  always_comb begin
    cnt_d = cnt_q;
    if (any_wr) begin
      // software write wins; a coincident event is dropped
      for (int h = 0; h < NHALF; h++) begin
        if (wr_half_i[h]) cnt_d[h*HALF_W +: HALF_W] = wdata_i;
      end
    end else if (inc_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = inc_i && !any_wr && (&cnt_q);
endmodule

// File: rtl/hpc_sel_reg.sv
module hpc_sel_reg
  import hpc_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NHALF-1:0]  wr_half_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              ovf_i,
  output logic [CNT_W-1:0]  sel_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] WMASK = sel_wmask(EVT_W);
  localparam int               OF_HALF = OF_BIT / HALF_W;

  logic [CNT_W-1:0] sel_q, sel_d;
  logic             irq_q, irq_d;

  always_comb begin
    sel_d = sel_q;
    irq_d = 1'b0;
    for (int h = 0; h < NHALF; h++) begin
      if (wr_half_i[h])
        sel_d[h*HALF_W +: HALF_W] = wdata_i & WMASK[h*HALF_W +: HALF_W];
    end
    // a flag-half write in the same cycle keeps its value, no request
    if (ovf_i && !sel_q[OF_BIT] && !wr_half_i[OF_HALF]) begin
      sel_d[OF_BIT] = 1'b1;
      irq_d         = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      irq_q <= irq_d;
    end
  end

  assign sel_o = sel_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/hpc_unit.sv
module hpc_unit
  import hpc_pkg::*;
#(
  parameter int NUM_EVT = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [2:0]         priv_i,
  input  logic               csr_we_i,
  input  logic               csr_reg_i,
  input  logic               csr_hi_i,
  input  logic [31:0]        csr_wdata_i,
  output logic [31:0]        csr_rdata_o,
  output logic [63:0]        cnt_o,
  output logic [63:0]        sel_o,
  output logic               of_o,
  output logic               irq_o
);
  localparam int EVT_W = $clog2(NUM_EVT + 1);

  logic [NHALF-1:0]     half_hit;
  logic [NHALF-1:0]     cnt_wr, sel_wr;
  logic [NUM_MODES-1:0] inh;
  logic                 inc, ovf;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign half_hit[h] = (csr_hi_i == 1'(h));
    assign cnt_wr[h]   = csr_we_i && !csr_reg_i && half_hit[h];
    assign sel_wr[h]   = csr_we_i &&  csr_reg_i && half_hit[h];
  end

  // inhibit bits run downward from just below the flag, M first
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_inh
    assign inh[m] = sel_o[INH_TOP - m];
  end

  hpc_mode_gate #(.NUM_EVT(NUM_EVT), .EVT_W(EVT_W)) u_gate (
    .evt_i  (evt_i),
    .code_i (sel_o[EVT_W-1:0]),
    .inh_i  (inh),
    .priv_i (priv_i),
    .en_o   (inc)
  );

  hpc_count_reg u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_half_i (cnt_wr),
    .wdata_i   (csr_wdata_i),
    .inc_i     (inc),
    .cnt_o     (cnt_o),
    .ovf_o     (ovf)
  );

  hpc_sel_reg #(.EVT_W(EVT_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_half_i (sel_wr),
    .wdata_i   (csr_wdata_i),
    .ovf_i     (ovf),
    .sel_o     (sel_o),
    .irq_o     (irq_o)
  );

  assign of_o = sel_o[OF_BIT];

  always_comb begin
    csr_rdata_o = '0;
    for (int h = 0; h < NHALF; h++) begin
      if (half_hit[h])
        csr_rdata_o = csr_reg_i ? sel_o[h*HALF_W +: HALF_W]
                                : cnt_o[h*HALF_W +: HALF_W];
    end
  end
endmodule

// File: rtl/hpc_unit_chk.sv
module hpc_unit_chk #(
  parameter int NUM_EVT = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_i,
  input logic [2:0]         priv_i,
  input logic               csr_we_i,
  input logic               csr_reg_i,
  input logic               csr_hi_i,
  input logic [31:0]        csr_wdata_i,
  input logic [63:0]        cnt_o,
  input logic [63:0]        sel_o,
  input logic               of_o,
  input logic               irq_o
);
  logic cnt_wr, cnt_wr_lo;
  assign cnt_wr    = csr_we_i && !csr_reg_i;
  assign cnt_wr_lo = cnt_wr && !csr_hi_i;

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 64'd1));

  a_r3_m_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 3'd0 && sel_o[62] && !cnt_wr) |=> $stable(cnt_o));

  a_r4_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == 64'd0 && !cnt_wr) |=> $stable(cnt_o));

  a_r5_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt_o) && !cnt_wr) |=> ((&cnt_o) || cnt_o == 64'd0));

  a_r6_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> of_o);

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r7_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(of_o));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o[57:4] == '0);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_lo |=> cnt_o[31:0] == $past(csr_wdata_i));
endmodule

bind hpc_unit hpc_unit_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_i       (evt_i),
  .priv_i      (priv_i),
  .csr_we_i    (csr_we_i),
  .csr_reg_i   (csr_reg_i),
  .csr_hi_i    (csr_hi_i),
  .csr_wdata_i (csr_wdata_i),
  .cnt_o       (cnt_o),
  .sel_o       (sel_o),
  .of_o        (of_o),
  .irq_o       (irq_o)
);

// File: tb/hpc_unit_tb.sv
`timescale 1ns/100ps
module hpc_unit_tb;
  localparam int NE = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt_i = '0;
  logic [2:0]    priv_i = 3'd0;
  logic          csr_we_i = 1'b0;
  logic          csr_reg_i = 1'b0;
  logic          csr_hi_i = 1'b0;
  logic [31:0]   csr_wdata_i = '0;
  logic [31:0]   csr_rdata_o;
  logic [63:0]   cnt_o, sel_o;
  logic          of_o, irq_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  hpc_unit #(.NUM_EVT(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .priv_i(priv_i),
    .csr_we_i(csr_we_i), .csr_reg_i(csr_reg_i), .csr_hi_i(csr_hi_i),
    .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
    .cnt_o(cnt_o), .sel_o(sel_o), .of_o(of_o), .irq_o(irq_o)
  );

  // scoreboard queues: kind 0 = state, kind 1 = read data
  string       q_tag[$];
  int          q_kind[$];
  logic [63:0] q_cnt[$], q_sel[$];
  logic        q_irq[$];
  logic [31:0] q_rd[$];
  event        chk_ev;

  task automatic push_state(input string tag, input logic [63:0] c,
                            input logic [63:0] s, input logic i);
    #1;
    q_tag.push_back(tag); q_kind.push_back(0);
    q_cnt.push_back(c); q_sel.push_back(s); q_irq.push_back(i); q_rd.push_back('0);
    -> chk_ev;
    #0.1;
  endtask

  task automatic push_read(input string tag, input bit r, input bit hi,
                           input logic [31:0] exp);
    csr_reg_i = r; csr_hi_i = hi;
    #1;
    q_tag.push_back(tag); q_kind.push_back(1);
    q_cnt.push_back('0); q_sel.push_back('0); q_irq.push_back(1'b0); q_rd.push_back(exp);
    -> chk_ev;
    #0.1;
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      while (q_tag.size() > 0) begin
        string t; int k; logic [63:0] c, s; logic i; logic [31:0] r;
        t = q_tag.pop_front(); k = q_kind.pop_front();
        c = q_cnt.pop_front(); s = q_sel.pop_front();
        i = q_irq.pop_front(); r = q_rd.pop_front();
        checks++;
        if (k == 0) begin
          if (cnt_o !== c || sel_o !== s || irq_o !== i || of_o !== s[63]) begin
            failures++;
            $display("FAIL %s: cnt=%h sel=%h irq=%b of=%b expected cnt=%h sel=%h irq=%b",
                     t, cnt_o, sel_o, irq_o, of_o, c, s, i);
          end
        end else if (csr_rdata_o !== r) begin
          failures++;
          $display("FAIL %s: rdata=%h expected %h", t, csr_rdata_o, r);
        end
      end
    end
  end

  task automatic csr_wr(input bit r, input bit hi, input logic [31:0] d,
                        input logic [NE-1:0] ev);
    @(negedge clk);
    csr_we_i = 1'b1; csr_reg_i = r; csr_hi_i = hi; csr_wdata_i = d; evt_i = ev;
    @(negedge clk);
    csr_we_i = 1'b0; evt_i = '0;
  endtask

  task automatic pulse(input logic [NE-1:0] ev, input int n);
    @(negedge clk);
    evt_i = ev;
    repeat (n) @(negedge clk);
    evt_i = '0;
  endtask

  task automatic set_cnt(input logic [63:0] v);
    csr_wr(1'b0, 1'b0, v[31:0], '0);
    csr_wr(1'b0, 1'b1, v[63:32], '0);
  endtask

  task automatic set_sel(input logic [63:0] v);
    csr_wr(1'b1, 1'b0, v[31:0], '0);
    csr_wr(1'b1, 1'b1, v[63:32], '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [NE-1:0] EV2 = NE'(1) << 2;
  localparam logic [63:0]   SEL3 = 64'h3;

  initial begin : driver
    logic [63:0] exp_c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    push_state("R1 reset", 64'd0, 64'd0, 1'b0);

    // R8 halves and read-back
    csr_wr(1'b0, 1'b0, 32'h1234_5678, '0);
    csr_wr(1'b0, 1'b1, 32'h9ABC_DEF0, '0);
    push_state("R8 counter halves", 64'h9ABC_DEF0_1234_5678, 64'd0, 1'b0);
    push_read("R8 read cnt lo", 1'b0, 1'b0, 32'h1234_5678);
    push_read("R8 read cnt hi", 1'b0, 1'b1, 32'h9ABC_DEF0);

    // R4 all-zero selector counts nothing
    pulse('1, 5);
    push_state("R4 zero selector", 64'h9ABC_DEF0_1234_5678, 64'd0, 1'b0);

    // R2 code 3 routes event line 2
    set_cnt(64'd0);
    csr_wr(1'b1, 1'b0, 32'h3, '0);
    push_read("R8 read sel lo", 1'b1, 1'b0, 32'h3);
    pulse(EV2, 4);
    push_state("R2 selected line counts", 64'd4, SEL3, 1'b0);
    pulse(~EV2, 3);
    push_state("R2 other lines ignored", 64'd4, SEL3, 1'b0);

    // R3 per-level inhibit
    exp_c = 64'd4;
    for (int m = 0; m < 5; m++) begin
      logic [63:0] s;
      s = SEL3 | (64'd1 << (62 - m));
      csr_wr(1'b1, 1'b1, s[63:32], '0);
      priv_i = 3'(m);
      pulse(EV2, 3);
      push_state("R3 inhibited level holds", exp_c, s, 1'b0);
      priv_i = 3'((m + 1) % 5);
      pulse(EV2, 2);
      exp_c = exp_c + 64'd2;
      push_state("R3 other level counts", exp_c, s, 1'b0);
    end
    csr_wr(1'b1, 1'b1, 32'h0, '0);
    for (int m = 0; m < 5; m++) begin
      priv_i = 3'(m);
      pulse(EV2, 1);
      exp_c = exp_c + 64'd1;
      push_state("R3 no inhibit counts everywhere", exp_c, SEL3, 1'b0);
    end
    priv_i = 3'd0;

    // R9 reserved bits read zero
    set_sel(64'hFFFF_FFFF_FFFF_FFFF);
    push_read("R9 sel lo masked", 1'b1, 1'b0, 32'h0000_000F);
    push_read("R9 sel hi masked", 1'b1, 1'b1, 32'hFC00_0000);
    set_sel(SEL3);

    // R5 / R6 overflow with flag clear
    set_cnt(64'hFFFF_FFFF_FFFF_FFFE);
    pulse(EV2, 1);
    push_state("R5 before carry", 64'hFFFF_FFFF_FFFF_FFFF, SEL3, 1'b0);
    pulse(EV2, 1);
    push_state("R6 carry sets flag and request", 64'd0, SEL3 | (64'd1 << 63), 1'b1);
    @(negedge clk);
    push_state("R6 request lasts one cycle", 64'd0, SEL3 | (64'd1 << 63), 1'b0);
    pulse(EV2, 2);
    push_state("R5 keeps counting after wrap", 64'd2, SEL3 | (64'd1 << 63), 1'b0);

    // R7 flag already set
    set_cnt(64'hFFFF_FFFF_FFFF_FFFF);
    pulse(EV2, 1);
    push_state("R7 no request when flag set", 64'd0, SEL3 | (64'd1 << 63), 1'b0);

    // R10 counter write beats event
    csr_wr(1'b0, 1'b0, 32'h0000_0100, EV2);
    push_state("R10 write wins over event", 64'h100, SEL3 | (64'd1 << 63), 1'b0);

    // R11 flag-half write coincident with overflow
    csr_wr(1'b1, 1'b1, 32'h0, '0);
    set_cnt(64'hFFFF_FFFF_FFFF_FFFF);
    csr_wr(1'b1, 1'b1, 32'h0, EV2);
    push_state("R11 written flag kept, no request", 64'd0, SEL3, 1'b0);

    // R6 again after software clear
    set_cnt(64'hFFFF_FFFF_FFFF_FFFF);
    pulse(EV2, 1);
    push_state("R6 request after clear", 64'd0, SEL3 | (64'd1 << 63), 1'b1);

    // R1 reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    push_state("R1 reset reapplied", 64'd0, 64'd0, 1'b0);

    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule